// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, from the destination address at the head of a received Ethernet frame, whether the frame should be kept. The destination bytes arrive one per accepted beat on a byte stream, and a start strobe marks the first of them. While the bytes stream in, the block tracks three things at once: whether every byte is 0xFF (broadcast), whether every byte equals the programmed station address, and a CRC-32 over the bytes that yields a 6-bit hash into a 64-bit group-address table.

One cycle after the last destination byte is taken, the block presents a registered accept decision and a group-address flag, marked valid by a one-cycle done strobe. A receive-configuration byte gates the decision. It has a promiscuous enable, a broadcast enable and a group-address enable. Frame storage, FCS checking and register access are handled elsewhere.

Top module: `rx_addr_filter`

## Requirements
- R1: Out of a synchronous active-high reset, `res_done`, `res_accept` and `res_group` are all 0.
- R2: `res_done` is high for exactly one cycle, in the cycle after the edge that takes the sixth destination byte. A byte is taken on an edge where `byte_vld` is high. Idle cycles with `byte_vld` low may fall between bytes.
- R3: When `rx_cfg[4]` (promiscuous) is 1, the frame is accepted whatever its destination.
- R4: When promiscuous is off, a destination of six 0xFF bytes is accepted only if `rx_cfg[2]` is 1.
- R5: When promiscuous is off, a non-broadcast destination whose first byte has bit 0 set is accepted only if `rx_cfg[3]` is 1 and the group table bit selected by its hash is 1.
- R6: The hash is taken from a CRC register that starts at 0xFFFFFFFF. It is fed the six bytes in order, each byte least significant bit first. For each bit, carry = CRC[31] XOR the data bit, and the CRC shifts left by one. If carry is 1, the CRC is then XORed with 0x04C11DB6 and bit 0 is set. The hash is CRC[31:26] after the last bit. It selects bit `hash` of `grp_table`, which is byte hash[5:3], bit hash[2:0], with table byte k held in bits 8k+7:8k.
- R7: When promiscuous is off, a destination that is neither broadcast nor group is accepted only if each byte k equals `station_addr[8k+7:8k]`, with byte 0 first on the stream.
- R8: `res_group` equals bit 0 of the first destination byte, so it is also 1 for broadcast. `res_accept` and `res_group` hold their values until the next `res_done`.
- R9: `byte_vld` with `byte_start` high always begins a new address, even if an earlier one was cut short. The earlier partial address produces no `res_done`.
- R10: Bytes taken while no address is in progress and without `byte_start` are ignored and produce no `res_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | A destination byte is present on `byte_data` |
| byte_start | input | 1 | Marks the byte as the first of the address (qualified by `byte_vld`) |
| byte_data | input | 8 | Destination byte |
| rx_cfg | input | 8 | Receive configuration: bit 2 broadcast, bit 3 group, bit 4 promiscuous |
| grp_table | input | 64 | Group-address hash table |
| station_addr | input | 48 | Station address, byte 0 in bits 7:0 |
| res_done | output | 1 | Decision valid strobe |
| res_accept | output | 1 | Frame accepted |
| res_group | output | 1 | Destination is a group (multicast or broadcast) address |

## Verification
The bench builds the block with its default parameters: a six-byte address, a 64-bit table and a 32-bit CRC, which are the values the filtering rules are defined for. With a fully random table, about half of all group addresses hit the table, so both outcomes of the hash lookup come up often. Broadcast, exact station matches and near-miss station addresses are driven on purpose, because random addresses almost never reach them. Random gaps between bytes, aborted addresses and stray bytes exercise the sequencing.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;
  localparam int CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFF_FFFF;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB6;
  localparam int CFG_PROMISC = 4;
  localparam int CFG_BCAST   = 2;
  localparam int CFG_GROUP   = 3;

  function automatic logic [CRC_W-1:0] crc_feed_byte(input logic [CRC_W-1:0] c_in,
                                                      input logic [7:0] d);
    logic [CRC_W-1:0] c;
    logic carry;
    c = c_in;
    for (int j = 0; j < 8; j++) begin
      carry = c[CRC_W-1] ^ d[j];
      c = c << 1;
      if (carry) c = (c ^ CRC_POLY) | {{(CRC_W-1){1'b0}}, 1'b1};
    end
    return c;
  endfunction
endpackage

// File: rtl/afilt_hash.sv
module afilt_hash
  import rx_addr_filter_pkg::*;
#(
  parameter int HASH_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [7:0]        din,
  output logic [HASH_W-1:0] hash_next
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_d;

  always_comb crc_d = crc_feed_byte(load ? CRC_INIT : crc_q, din);
  assign hash_next = crc_d[CRC_W-1 -: HASH_W];

  always_ff @(posedge clk) begin
    if (rst)              crc_q <= CRC_INIT;
    else if (load || step) crc_q <= crc_d;
  end

  // R6
  crc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(crc_q));
endmodule

// File: rtl/afilt_match.sv
module afilt_match #(
  parameter int NBYTES = 6,
  localparam int IDX_W = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        din,
  input  logic [8*NBYTES-1:0] station,
  output logic              bcast_next,
  output logic              stn_next,
  output logic              grp_next
);
  logic bcast_q, stn_q, grp_q;

  always_comb begin
    bcast_next = (load ? 1'b1 : bcast_q) & (din == 8'hFF);
    stn_next   = (load ? 1'b1 : stn_q) & (din == station[idx*8 +: 8]);
    grp_next   = load ? din[0] : grp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bcast_q <= 1'b0;
      stn_q   <= 1'b0;
      grp_q   <= 1'b0;
    end else if (load || step) begin
      bcast_q <= bcast_next;
      stn_q   <= stn_next;
      grp_q   <= grp_next;
    end
  end

  // R8
  grp_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (grp_q == $past(din[0])));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_addr_filter_pkg::*;
#(
  parameter int NBYTES  = 6,
  parameter int TABLE_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                byte_vld,
  input  logic                byte_start,
  input  logic [7:0]          byte_data,
  input  logic [7:0]          rx_cfg,
  input  logic [TABLE_W-1:0]  grp_table,
  input  logic [8*NBYTES-1:0] station_addr,
  output logic                res_done,
  output logic                res_accept,
  output logic                res_group
);
  localparam int IDX_W  = $clog2(NBYTES);
  localparam int HASH_W = $clog2(TABLE_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

  logic             active_q;
  logic [IDX_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx;
  logic             load, step, fire;
  logic [HASH_W-1:0] hash_nx;
  logic bcast_nx, stn_nx, grp_nx;
  logic decide;

  assign load = byte_vld && byte_start;
  assign step = byte_vld && !byte_start && active_q;
  assign idx  = load ? '0 : cnt_q;
  assign fire = (load || step) && (idx == LAST_IDX);

  afilt_hash #(.HASH_W(HASH_W)) u_hash (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .din(byte_data), .hash_next(hash_nx)
  );

  afilt_match #(.NBYTES(NBYTES)) u_match (
    .clk(clk), .rst(rst), .load(load), .step(step), .idx(idx),
    .din(byte_data), .station(station_addr),
    .bcast_next(bcast_nx), .stn_next(stn_nx), .grp_next(grp_nx)
  );

  always_comb begin
    if (rx_cfg[CFG_PROMISC])  decide = 1'b1;
    else if (bcast_nx)        decide = rx_cfg[CFG_BCAST];
    else if (grp_nx)          decide = rx_cfg[CFG_GROUP] && grp_table[hash_nx];
    else                      decide = stn_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= 1'b0;
      cnt_q      <= '0;
      res_done   <= 1'b0;
      res_accept <= 1'b0;
      res_group  <= 1'b0;
    end else begin
      res_done <= fire;
      if (fire) begin
        active_q   <= 1'b0;
        cnt_q      <= '0;
        res_accept <= decide;
        res_group  <= grp_nx;
      end else if (load || step) begin
        active_q <= 1'b1;
        cnt_q    <= idx + 1'b1;
      end
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_done |=> !res_done);
  // R2
  done_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
    res_done |-> $past(byte_vld));
  // R3
  promisc_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && rx_cfg[CFG_PROMISC]) |=> (res_done && res_accept));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fire |=> ($stable(res_accept) && $stable(res_group)));
endmodule

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
  logic clk = 1'b0;
  logic rst;
  logic byte_vld, byte_start;
  logic [7:0] byte_data, rx_cfg;
  logic [63:0] grp_table;
  logic [47:0] station_addr;
  logic res_done, res_accept, res_group;
  int n_chk = 0, n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  rx_addr_filter i_rx_addr_filter (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_start(byte_start),
    .byte_data(byte_data), .rx_cfg(rx_cfg), .grp_table(grp_table),
    .station_addr(station_addr), .res_done(res_done),
    .res_accept(res_accept), .res_group(res_group)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // independent hash model: CRC run bit-serially over a 48-bit vector
  function automatic logic [5:0] ref_hash(input logic [47:0] da);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int b = 0; b < 48; b++) begin
      logic top = r[31];
      r = {r[30:0], 1'b0};
      if (top ^ da[b]) r = {r[31:1] ^ 31'h0260_8EDB, 1'b1};
    end
    return r[31:26];
  endfunction

  function automatic logic ref_accept(input logic [47:0] da, input logic [7:0] cfg,
                                      input logic [63:0] tbl, input logic [47:0] st);
    logic [5:0] h;
    if (cfg[4]) return 1'b1;
    if (da == 48'hFFFF_FFFF_FFFF) return cfg[2];
    if (da[0]) begin
      h = ref_hash(da);
      return cfg[3] & tbl[{h[5:3], h[2:0]}];
    end
    return da == st;
  endfunction

  task automatic idle;
    byte_vld = 1'b0; byte_start = 1'b0; byte_data = 8'h00;
  endtask

  // drive one address; gaps when gap!=0; checks R2 timing and result
  task automatic send(input logic [47:0] da, input bit gap, input string req);
    for (int i = 0; i < 6; i++) begin
      if (gap) begin
        int g = int'($urandom_range(0, 2));
        for (int k = 0; k < g; k++) begin
          @(negedge clk); idle;
          chk("R2 no early done", res_done, 0);
        end
      end
      @(negedge clk);
      if (i != 0) chk("R2 no early done", res_done, 0);
      byte_vld = 1'b1; byte_start = (i == 0); byte_data = da[i*8 +: 8];
    end
    @(negedge clk); idle;
    chk("R2 done", res_done, 1);
    chk({req, " accept"}, res_accept, ref_accept(da, rx_cfg, grp_table, station_addr));
    chk("R8 group flag", res_group, da[0]);
    @(negedge clk);
    chk("R2 done one cycle", res_done, 0);
    chk("R8 hold", res_group, da[0]);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [47:0] da;
    void'($urandom(32'd1357));
    idle;
    rx_cfg = 8'h00; grp_table = 64'h0; station_addr = 48'h5634_1200_AB02;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done", res_done, 0);
    chk("R1 accept", res_accept, 0);
    chk("R1 group", res_group, 0);

    // R3 promiscuous
    rx_cfg = 8'h10;
    send(48'h1122_3344_5566, 0, "R3");
    send(48'hFFFF_FFFF_FFFF, 0, "R3");
    // R4 broadcast
    rx_cfg = 8'h00; send(48'hFFFF_FFFF_FFFF, 0, "R4 off");
    rx_cfg = 8'h04; send(48'hFFFF_FFFF_FFFF, 0, "R4 on");
    // R7 station exact and near miss
    send(station_addr, 0, "R7 match");
    send(station_addr ^ 48'h8000_0000_0000, 0, "R7 miss");
    // R5/R6 group: hit and miss on single table bit
    da = 48'h0000_0000_5E01;
    rx_cfg = 8'h08;
    grp_table = 64'h1 << ref_hash(da);
    send(da, 0, "R6 hit");
    grp_table = ~(64'h1 << ref_hash(da));
    send(da, 0, "R6 miss");
    rx_cfg = 8'h04; grp_table = '1;
    send(da, 0, "R5 disabled");

    // R9 restart after partial address
    rx_cfg = 8'h00;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      byte_vld = 1'b1; byte_start = (i == 0); byte_data = 8'hEE;
    end
    send(station_addr, 0, "R9 restart");

    // R10 stray bytes when idle
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      byte_vld = 1'b1; byte_start = 1'b0; byte_data = 8'hFF;
      if (i > 0) chk("R10 stray ignored", res_done, 0);
    end
    @(negedge clk); idle;
    chk("R10 stray ignored", res_done, 0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      rx_cfg = 8'($urandom);
      grp_table = {$urandom, $urandom};
      station_addr = {16'($urandom), $urandom};
      case ($urandom_range(0, 3))
        0: da = 48'hFFFF_FFFF_FFFF;
        1: da = station_addr;
        2: da = {16'($urandom), $urandom} | 48'h1;
        default: da = {16'($urandom), $urandom};
      endcase
      send(da, 1, "R5 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule